// File: doc/BRIEF.md
# Decrement-and-Branch Loop Unit

This unit executes a loop-closing instruction: it counts a general register down by one and redirects the instruction counter when the new count is not zero. Two encodings are handled. The short form names the count register and a register that holds the target address. The long form names the count register and builds the target from an index register, a base register and a 12-bit displacement.

The unit sits beside an external general register file. It decodes the instruction word on the cycle that `ins_valid` is high and drives the three read addresses from that word. The register file returns the read data in the same cycle. One clock later the unit presents the write-back (`rf_we`, `rf_wa`, `rf_wd`), the next instruction-counter value and a taken flag. Opcodes it does not own raise `bad_op` for one cycle instead. Instructions must be issued at least two cycles apart, so that the register file has absorbed the previous write before the next read.

Top module: `dbr_unit`

## Requirements
- R1: The opcode sits in bits 31:24 and the count-register field in bits 23:20. Opcode 0x06 is the 16-bit short form, with its target-register field in bits 19:16. Opcode 0x46 is the 32-bit long form, with index field 19:16, base field 15:12 and displacement 11:0. For both forms `br_done` pulses for one cycle, in the cycle after the instruction is accepted.
- R2: In that same cycle `rf_we` is 1, `rf_wa` holds the count field and `rf_wd` holds the count register's value minus one, modulo 2^32.
- R3: `br_taken` is 1 exactly when the decremented value is nonzero, unless R5 applies. An initial count of 1 does not branch. An initial count of 0 branches and writes 0xFFFFFFFF.
- R4: Decrementing 0x80000000 writes 0x7FFFFFFF, branches normally and raises no flag (`bad_op` stays 0).
- R5: In the short form, a target field of 0 still decrements and writes back, but the branch is never taken.
- R6: A taken long form sets `br_next_ic` to the low 24 bits of index + base + zero-extended displacement. A field of 0 contributes zero instead of register 0.
- R7: When no branch is taken, `br_next_ic` is `cur_ic` + 2 for the short form and `cur_ic` + 4 for the long form, modulo 2^24.
- R8: A taken short form sets `br_next_ic` to the low 24 bits of the target register as read before the write-back. This holds even when the target and count fields name the same register.
- R9: Any other opcode gives `bad_op` = 1 for one cycle, with `rf_we`, `br_taken` and `br_done` all 0 and `br_next_ic` unchanged.
- R10: After reset, and in any cycle that follows a cycle without `ins_valid`, `br_done`, `br_taken`, `rf_we` and `bad_op` are 0 and `br_next_ic` holds its value (0 after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction word present this cycle |
| ins_word | input | 32 | Instruction, opcode in the top byte |
| cur_ic | input | 24 | Address of the current instruction |
| rf_ra_cnt | output | 4 | Read address, count register |
| rf_ra_a | output | 4 | Read address, target or index register |
| rf_ra_b | output | 4 | Read address, base register |
| rf_rd_cnt | input | 32 | Read data, count register |
| rf_rd_a | input | 32 | Read data, target or index register |
| rf_rd_b | input | 32 | Read data, base register |
| rf_we | output | 1 | Write-back strobe |
| rf_wa | output | 4 | Write-back register number |
| rf_wd | output | 32 | Decremented count |
| br_done | output | 1 | Loop instruction completed |
| br_taken | output | 1 | Branch taken |
| br_next_ic | output | 24 | Next instruction-counter value |
| bad_op | output | 1 | Opcode not handled by this unit |

## Verification
The assertions are checked on every cycle. They cover the rules that hold cycle by cycle: an unsupported opcode never writes or branches, a taken branch always comes with a nonzero write-back, writes go only to the register named by the accepted count field, and idle cycles leave the outputs quiet with the counter held. Only the bench scenarios can show the arithmetic itself. The bench sweeps every count-field and target-field pair of the short form and every index-base pair of the long form. It mixes in counts of 0, 1 and the most negative value, and a current counter near the top of the 24-bit range. From these runs it confirms the wrap-around results, the fall-through offsets, and the read-before-write target when the two fields name the same register.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  localparam logic [7:0] OPC_SHORT = 8'h06;
  localparam logic [7:0] OPC_LONG  = 8'h46;

  typedef enum logic [1:0] {
    FORM_NONE  = 2'd0,
    FORM_SHORT = 2'd1,
    FORM_LONG  = 2'd2
  } form_e;
endpackage

// File: rtl/dbr_decode.sv
module dbr_decode
  import dbr_pkg::*;
#(
  parameter int IW  = 32,
  parameter int RAW = 4,
  parameter int DW  = 12
) (
  input  logic [IW-1:0]  word,
  output form_e          form,
  output logic [RAW-1:0] fld_cnt,
  output logic [RAW-1:0] fld_a,
  output logic [RAW-1:0] fld_b,
  output logic [DW-1:0]  disp,
  output logic           use_a,
  output logic           use_b
);
  localparam int OPC_HI = IW - 1;
  localparam int CNT_HI = IW - 9;
  localparam int A_HI   = CNT_HI - RAW;
  localparam int B_HI   = A_HI - RAW;

  logic [7:0] opc;

  assign opc     = word[OPC_HI -: 8];
  assign fld_cnt = word[CNT_HI -: RAW];
  assign fld_a   = word[A_HI -: RAW];
  assign fld_b   = word[B_HI -: RAW];
  assign disp    = word[DW-1:0];

  always_comb begin
    unique case (opc)
      OPC_SHORT: form = FORM_SHORT;
      OPC_LONG:  form = FORM_LONG;
      default:   form = FORM_NONE;
    endcase
  end

  // a nonzero field selects the register; zero means "no register"
  assign use_a = (fld_a != '0);
  assign use_b = (form == FORM_LONG) && (fld_b != '0);
endmodule

// File: rtl/dbr_count.sv
module dbr_count #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] cnt_in,
  output logic [XLEN-1:0] cnt_dec,
  output logic            cnt_nz
);
  // plain modular subtraction: overflow is discarded on purpose
  assign cnt_dec = cnt_in - XLEN'(1);
  assign cnt_nz  = |cnt_dec;
endmodule

// File: rtl/dbr_target.sv
module dbr_target
  import dbr_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int AW          = 24,
  parameter int DW          = 12,
  parameter int SHORT_BYTES = 2,
  parameter int LONG_BYTES  = 4
) (
  input  form_e           form,
  input  logic            use_a,
  input  logic            use_b,
  input  logic [XLEN-1:0] rd_a,
  input  logic [XLEN-1:0] rd_b,
  input  logic [DW-1:0]   disp,
  input  logic [AW-1:0]   cur_ic,
  output logic [AW-1:0]   tgt,
  output logic [AW-1:0]   seq,
  output logic            may_branch
);
  logic [XLEN-1:0] op_a, op_b, sum;
  logic [AW-1:0]   step;

  assign op_a = use_a ? rd_a : '0;
  assign op_b = use_b ? rd_b : '0;
  assign sum  = op_a + op_b + XLEN'(disp);

  always_comb begin
    if (form == FORM_LONG) begin
      tgt        = sum[AW-1:0];
      step       = AW'(LONG_BYTES);
      may_branch = 1'b1;
    end else begin
      tgt        = rd_a[AW-1:0];
      step       = AW'(SHORT_BYTES);
      may_branch = use_a;
    end
  end

  assign seq = cur_ic + step;
endmodule

// File: rtl/dbr_unit.sv
module dbr_unit
  import dbr_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 24,
  parameter int RAW  = 4,
  parameter int DW   = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ins_valid,
  input  logic [31:0]     ins_word,
  input  logic [AW-1:0]   cur_ic,
  output logic [RAW-1:0]  rf_ra_cnt,
  output logic [RAW-1:0]  rf_ra_a,
  output logic [RAW-1:0]  rf_ra_b,
  input  logic [XLEN-1:0] rf_rd_cnt,
  input  logic [XLEN-1:0] rf_rd_a,
  input  logic [XLEN-1:0] rf_rd_b,
  output logic            rf_we,
  output logic [RAW-1:0]  rf_wa,
  output logic [XLEN-1:0] rf_wd,
  output logic            br_done,
  output logic            br_taken,
  output logic [AW-1:0]   br_next_ic,
  output logic            bad_op
);
  form_e           form;
  logic [RAW-1:0]  f_cnt, f_a, f_b;
  logic [DW-1:0]   disp;
  logic            use_a, use_b;
  logic [XLEN-1:0] dec;
  logic            nz;
  logic [AW-1:0]   tgt, seq;
  logic            may_branch;
  logic            known, fire, take;

  dbr_decode #(.IW(32), .RAW(RAW), .DW(DW)) u_dec (
    .word(ins_word), .form(form), .fld_cnt(f_cnt), .fld_a(f_a), .fld_b(f_b),
    .disp(disp), .use_a(use_a), .use_b(use_b)
  );

  dbr_count #(.XLEN(XLEN)) u_cnt (
    .cnt_in(rf_rd_cnt), .cnt_dec(dec), .cnt_nz(nz)
  );

  dbr_target #(.XLEN(XLEN), .AW(AW), .DW(DW)) u_tgt (
    .form(form), .use_a(use_a), .use_b(use_b), .rd_a(rf_rd_a), .rd_b(rf_rd_b),
    .disp(disp), .cur_ic(cur_ic), .tgt(tgt), .seq(seq), .may_branch(may_branch)
  );

  assign rf_ra_cnt = f_cnt;
  assign rf_ra_a   = f_a;
  assign rf_ra_b   = f_b;

  assign known = (form != FORM_NONE);
  assign fire  = ins_valid && known;
  assign take  = may_branch && nz;

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_we      <= 1'b0;
      rf_wa      <= '0;
      rf_wd      <= '0;
      br_done    <= 1'b0;
      br_taken   <= 1'b0;
      br_next_ic <= '0;
      bad_op     <= 1'b0;
    end else begin
      rf_we    <= fire;
      br_done  <= fire;
      br_taken <= fire && take;
      bad_op   <= ins_valid && !known;
      if (fire) begin
        rf_wa      <= f_cnt;
        rf_wd      <= dec;
        br_next_ic <= take ? tgt : seq;
      end
    end
  end

  // R9
  unsup_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    bad_op |-> (!rf_we && !br_taken && !br_done));

  // R3
  taken_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> (rf_wd != '0));

  // R2
  write_source_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> ($past(ins_valid) && rf_wa == $past(rf_ra_cnt)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(ins_valid) |-> (!rf_we && !bad_op && !br_done && $stable(br_next_ic)));

  // R9
  unsup_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bad_op |-> $stable(br_next_ic));
endmodule

// File: tb/sim_dbr_unit.sv
`timescale 1ns/1ps
module sim_dbr_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ins_valid = 1'b0;
  logic [31:0] ins_word = '0;
  logic [23:0] cur_ic = '0;
  logic [3:0]  ra_cnt, ra_a, ra_b;
  logic [31:0] rd_cnt, rd_a, rd_b;
  logic        rf_we, br_done, br_taken, bad_op;
  logic [3:0]  rf_wa;
  logic [31:0] rf_wd;
  logic [23:0] br_next_ic;
  logic [31:0] rf [16];
  int          errs = 0;
  int          checks = 0;
  bit          ended = 1'b0;

  always #4 clk = ~clk;

  assign rd_cnt = rf[ra_cnt];
  assign rd_a   = rf[ra_a];
  assign rd_b   = rf[ra_b];

  dbr_unit u0 (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_word(ins_word), .cur_ic(cur_ic),
    .rf_ra_cnt(ra_cnt), .rf_ra_a(ra_a), .rf_ra_b(ra_b),
    .rf_rd_cnt(rd_cnt), .rf_rd_a(rd_a), .rf_rd_b(rd_b),
    .rf_we(rf_we), .rf_wa(rf_wa), .rf_wd(rf_wd),
    .br_done(br_done), .br_taken(br_taken), .br_next_ic(br_next_ic), .bad_op(bad_op)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 16; i++) rf[i] = 32'hF0F0_0000 + 32'(i * 32'h12345) + 32'(seed * 977);
  endtask

  // issue one instruction, check the result cycle and the idle cycle after it
  task automatic run_ins(input logic [31:0] w, input logic [23:0] ic);
    logic [7:0]  opc;
    logic [3:0]  r1, fa, fb;
    logic [31:0] cnt, dec, sum;
    logic [23:0] prev, exp_ic;
    bit          known, lng, tk;
    opc = w[31:24]; r1 = w[23:20]; fa = w[19:16]; fb = w[15:12];
    lng = (opc == 8'h46);
    known = lng || (opc == 8'h06);
    cnt = rf[r1];
    dec = cnt - 32'd1;
    tk = (dec != 0) && (lng || fa != 0);
    sum = (fa != 0 ? rf[fa] : 32'd0) + (lng && fb != 0 ? rf[fb] : 32'd0) + {20'd0, w[11:0]};
    prev = br_next_ic;
    if (!known) exp_ic = prev;
    else if (tk) exp_ic = lng ? sum[23:0] : rf[fa][23:0];
    else exp_ic = ic + (lng ? 24'd4 : 24'd2);
    @(negedge clk);
    ins_valid = 1'b1; ins_word = w; cur_ic = ic;
    @(negedge clk);
    ins_valid = 1'b0;
    if (!known) begin
      chk(bad_op && !rf_we && !br_taken && !br_done, "R9 unsupported quiet",
          {28'd0, bad_op, rf_we, br_taken, br_done}, 32'h8);
      chk(br_next_ic == exp_ic, "R9 counter held", {8'd0, br_next_ic}, {8'd0, exp_ic});
    end else begin
      chk(br_done && !bad_op, "R1 done pulse", {30'd0, br_done, bad_op}, 32'h2);
      chk(rf_we && rf_wa == r1, "R2 write address", {27'd0, rf_we, rf_wa}, {27'd1, r1});
      chk(rf_wd == dec, (cnt == 32'h8000_0000) ? "R4 wrap result" : "R2 write data", rf_wd, dec);
      chk(br_taken == tk, (!lng && fa == 0) ? "R5 count only" : "R3 taken flag",
          {31'd0, br_taken}, {31'd0, tk});
      chk(br_next_ic == exp_ic, !tk ? "R7 fall through" : (lng ? "R6 indexed target" : "R8 register target"),
          {8'd0, br_next_ic}, {8'd0, exp_ic});
      if (rf_we) rf[rf_wa] = rf_wd;
    end
    @(negedge clk);
    chk(!br_done && !rf_we && !bad_op && !br_taken && br_next_ic == exp_ic, "R10 idle after",
        {8'd0, br_next_ic}, {8'd0, exp_ic});
  endtask

  localparam logic [31:0] CNTS [8] = '{32'd0, 32'd1, 32'd2, 32'hFFFF_FFFF,
                                       32'h8000_0000, 32'h7FFF_FFFF, 32'h100, 32'd5};
  localparam logic [7:0] BADS [6] = '{8'h00, 8'h05, 8'h07, 8'h47, 8'hFF, 8'h86};

  initial begin
    fill(0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!rf_we && !br_done && !br_taken && !bad_op && br_next_ic == 24'd0, "R10 reset state",
        {8'd0, br_next_ic}, 32'd0);
    // short form: every count / target field pair
    for (int a = 0; a < 16; a++) begin
      for (int t = 0; t < 16; t++) begin
        fill(a * 16 + t);
        rf[a] = CNTS[(a + t) % 8];
        run_ins({8'h06, 4'(a), 4'(t), 16'h0000}, ((a + t) % 3 == 0) ? 24'hFFFFFF : 24'(a * 4096 + t * 2));
      end
    end
    // long form: every index / base pair, count register rotating
    for (int x = 0; x < 16; x++) begin
      for (int b = 0; b < 16; b++) begin
        fill(x * 31 + b);
        rf[(x + b) % 16] = CNTS[(x * 3 + b) % 8];
        run_ins({8'h46, 4'((x + b) % 16), 4'(x), 4'(b), 12'((x * 16 + b) * 17)},
                ((x + b) % 4 == 0) ? 24'hFFFFFD : 24'(x * 8192 + b * 4));
      end
    end
    // unsupported opcodes
    for (int k = 0; k < 6; k++) begin
      fill(k);
      run_ins({BADS[k], 4'(k), 4'(k + 1), 16'h1234}, 24'h000100);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    ended = 1'b1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule